// File: doc/BRIEF.md
# Root Hub Downstream Port Control and Status

This block holds the control and status state of every downstream port of a USB root hub and presents it as one 32-bit word per port. Software reads that word to learn whether a device is attached, whether the port is powered, enabled, suspended, in reset or over-current, and whether a low-speed device sits on it. Five sticky change flags report events that happened since software last looked.

Writes do not store data. Each written bit position is a one-shot command, and many positions mean something unrelated to what they return on a read. A 1 starts the command and a 0 does nothing. In the upper half of the word a 1 acknowledges, and so clears, the matching change flag. The port's electrical side supplies a connect detect, a low-speed detect, an over-current level and a one-cycle pulse from an external reset timer. The block returns a reset-in-progress level to that timer and a one-cycle resume request to the resume timer.

Top module: `rh_port_ctl`

## Requirements
- R1: While reset is held and right after it, every port reads 0x00000000, and reset_active and resume_pulse are all low.
- R2: Writing 1 to bit 8 powers an unpowered port, and bit 8 then reads 1, unless over_current is high. Writing 1 to bit 9 removes power. A write of all zeros changes nothing.
- R3: While a port is unpowered, bits 0–4 and 9 read 0 and the set-enable (bit 1), set-suspend (bit 2) and start-reset (bit 4) commands are ignored.
- R4: For a powered port, bit 0 shows dev_connect as sampled at the last clock edge. Any change of that input sets connect-change (bit 16).
- R5: Writing 1 to bit 1 enables a powered port whose bit 0 reads 1, and bit 1 then reads 1. With no device connected the port stays disabled and bit 16 is set instead.
- R6: Writing 1 to bit 0 disables the port and ends suspend. A disconnect clears enable, suspend and reset, and sets enable-change (bit 17) if the port was enabled.
- R7: Writing 1 to bit 2 suspends an enabled port. Writing 1 to bit 3 on a suspended port ends suspend, sets suspend-change (bit 18) and raises resume_pulse for exactly one cycle.
- R8: Writing 1 to bit 4 on a connected port sets bit 4 and reset_active. Without a device it sets bit 16 instead. A reset_done pulse during reset clears bit 4, sets bit 1 and sets reset-change (bit 20).
- R9: over_current high on a powered port removes power, enable, suspend and reset at the next edge and sets over-current-change (bit 19), plus bit 17 if the port was enabled. Bit 3 reads over_current while the port is powered.
- R10: Bit 9 reads dev_low_speed while the port is powered and bit 0 reads 1.
- R11: Bits 16–20 stay set until a write with a 1 in that position clears them. If an event sets a flag in the same cycle as such a write, the flag ends up set.
- R12: A write to one port changes no other port.
- R13: Bits 5–7, 10–15 and 21–31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_port | input | PW | Port addressed by the write |
| wr_data | input | 32 | Command bits for the write |
| rd_port | input | PW | Port selected for readback |
| rd_data | output | 32 | Status word of the selected port |
| dev_connect | input | NPORTS | Device present, one per port |
| dev_low_speed | input | NPORTS | Attached device is low speed |
| over_current | input | NPORTS | Over-current level per port |
| reset_done | input | NPORTS | One-cycle end-of-reset pulse from the timer |
| reset_active | output | NPORTS | Port reset in progress |
| resume_pulse | output | NPORTS | One-cycle resume request |

## Verification
The assertions take every input as synchronous to clk. They expect reset_done to matter only while a reset is in progress. They also expect at most one write to be addressed per cycle, so their implications are phrased against the registered port state and not against a particular input order. The bench changes inputs only on falling edges and drives reset_done as a single-cycle pulse. Connect and over-current events are rare in the random stimulus, so enable, suspend and reset sequences get the chance to complete between them.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
   localparam int WORD_W  = 32;
   localparam int CHG_N   = 5;
   localparam int CHG_LSB = 16;

   // change flag slots inside the five-bit change field
   localparam int CG_CONN = 0;
   localparam int CG_EN   = 1;
   localparam int CG_SUSP = 2;
   localparam int CG_OC   = 3;
   localparam int CG_RST  = 4;

   typedef struct packed {
      logic             set_pwr;
      logic             clr_pwr;
      logic             set_en;
      logic             clr_en;
      logic             set_susp;
      logic             clr_susp;
      logic             set_rst;
      logic [CHG_N-1:0] ack_chg;
   } port_cmd_t;

   typedef struct packed {
      logic [CHG_N-1:0] chg;
      logic             ls;
      logic             pwr;
      logic             rst;
      logic             oc;
      logic             susp;
      logic             en;
      logic             conn;
   } port_view_t;

   function automatic logic [WORD_W-1:0] pack_view(input port_view_t v);
      logic [WORD_W-1:0] w;
      w = '0;
      w[0] = v.conn;
      w[1] = v.en;
      w[2] = v.susp;
      w[3] = v.oc;
      w[4] = v.rst;
      w[8] = v.pwr;
      w[9] = v.ls;
      w[CHG_LSB +: CHG_N] = v.chg;
      return w;
   endfunction
endpackage

// File: rtl/rhp_wr_decode.sv
module rhp_wr_decode
   import rhp_pkg::*;
#(
   parameter int NPORTS = 4,
   parameter int PW     = 2
) (
   input  logic              wr_en,
   input  logic [PW-1:0]     wr_port,
   input  logic [WORD_W-1:0] wr_data,
   output port_cmd_t         cmd [NPORTS]
);
   for (genvar i = 0; i < NPORTS; i++) begin : g_dec
      logic hit;
      assign hit = wr_en && (wr_port == PW'(i));
      always_comb begin
         cmd[i]          = '0;
         cmd[i].clr_en   = hit & wr_data[0];
         cmd[i].set_en   = hit & wr_data[1];
         cmd[i].set_susp = hit & wr_data[2];
         cmd[i].clr_susp = hit & wr_data[3];
         cmd[i].set_rst  = hit & wr_data[4];
         cmd[i].set_pwr  = hit & wr_data[8];
         cmd[i].clr_pwr  = hit & wr_data[9];
         cmd[i].ack_chg  = hit ? wr_data[CHG_LSB +: CHG_N] : '0;
      end
   end
endmodule

// File: rtl/rhp_port.sv
module rhp_port
   import rhp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  port_cmd_t  cmd,
   input  logic       dev_connect,
   input  logic       dev_low_speed,
   input  logic       over_current,
   input  logic       reset_done,
   output port_view_t view,
   output logic       reset_active,
   output logic       resume_pulse
);
   logic conn_q, en_q, susp_q, rst_q, pwr_q, resume_q;
   logic conn_d, en_d, susp_d, rst_d, pwr_d, resume_d;
   logic [CHG_N-1:0] chg_q, chg_d;

   always_comb begin
      conn_d   = conn_q;
      en_d     = en_q;
      susp_d   = susp_q;
      rst_d    = rst_q;
      pwr_d    = pwr_q;
      resume_d = 1'b0;
      chg_d    = chg_q & ~cmd.ack_chg;
      if (pwr_q) begin
         if (cmd.set_en) begin
            if (conn_q) en_d = 1'b1;
            else        chg_d[CG_CONN] = 1'b1;
         end
         if (cmd.set_susp && en_q) susp_d = 1'b1;
         if (cmd.clr_en) begin
            en_d   = 1'b0;
            susp_d = 1'b0;
         end
         if (cmd.clr_susp && susp_q) begin
            susp_d         = 1'b0;
            chg_d[CG_SUSP] = 1'b1;
            resume_d       = 1'b1;
         end
         if (cmd.set_rst) begin
            if (conn_q) rst_d = 1'b1;
            else        chg_d[CG_CONN] = 1'b1;
         end
         if (reset_done && rst_q) begin
            rst_d         = 1'b0;
            en_d          = 1'b1;
            chg_d[CG_RST] = 1'b1;
         end
         conn_d = dev_connect;
         if (dev_connect != conn_q) chg_d[CG_CONN] = 1'b1;
         if (conn_q && !dev_connect) begin
            if (en_q) chg_d[CG_EN] = 1'b1;
            en_d   = 1'b0;
            susp_d = 1'b0;
            rst_d  = 1'b0;
         end
         if (over_current) begin
            pwr_d        = 1'b0;
            chg_d[CG_OC] = 1'b1;
            if (en_q) chg_d[CG_EN] = 1'b1;
            conn_d = 1'b0;
            en_d   = 1'b0;
            susp_d = 1'b0;
            rst_d  = 1'b0;
         end
         if (cmd.clr_pwr) begin
            pwr_d  = 1'b0;
            conn_d = 1'b0;
            en_d   = 1'b0;
            susp_d = 1'b0;
            rst_d  = 1'b0;
         end
      end else if (cmd.set_pwr && !over_current) begin
         pwr_d = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         conn_q   <= 1'b0;
         en_q     <= 1'b0;
         susp_q   <= 1'b0;
         rst_q    <= 1'b0;
         pwr_q    <= 1'b0;
         resume_q <= 1'b0;
         chg_q    <= '0;
      end else begin
         conn_q   <= conn_d;
         en_q     <= en_d;
         susp_q   <= susp_d;
         rst_q    <= rst_d;
         pwr_q    <= pwr_d;
         resume_q <= resume_d;
         chg_q    <= chg_d;
      end
   end

   always_comb begin
      view      = '0;
      view.pwr  = pwr_q;
      view.conn = pwr_q & conn_q;
      view.en   = pwr_q & en_q;
      view.susp = pwr_q & susp_q;
      view.rst  = pwr_q & rst_q;
      view.oc   = pwr_q & over_current;
      view.ls   = pwr_q & conn_q & dev_low_speed;
      view.chg  = chg_q;
   end

   assign reset_active = rst_q;
   assign resume_pulse = resume_q;

   // R3: an unpowered port holds no status
   p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_q |-> !(conn_q || en_q || susp_q || rst_q));
   // R5: an enabled port always has a device behind it
   p_en_needs_conn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> conn_q);
   // R7: suspend only exists on an enabled port
   p_susp_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      susp_q |-> en_q);
   // R7: resume request lasts a single cycle
   p_resume_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resume_q |=> !resume_q);
   // R9: over-current drops power and raises its change flag
   p_oc_drops_power_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_q && over_current) |=> (!pwr_q && chg_q[CG_OC]));
   // R8: reset completion enables the port and flags it
   p_reset_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_q && rst_q && reset_done && dev_connect && !over_current && !cmd.clr_pwr)
      |=> (en_q && !rst_q && chg_q[CG_RST]));
   // R11: change flags never clear without an acknowledge
   p_chg_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_q[CG_CONN] && !cmd.ack_chg[CG_CONN]) |=> chg_q[CG_CONN]);
endmodule

// File: rtl/rhp_rd_mux.sv
module rhp_rd_mux
   import rhp_pkg::*;
#(
   parameter int NPORTS   = 4,
   parameter int PW       = 2,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PW-1:0]     rd_port,
   input  port_view_t        views [NPORTS],
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] sel_c;

   always_comb begin
      sel_c = '0;
      for (int i = 0; i < NPORTS; i++) begin
         if (rd_port == PW'(i)) sel_c = pack_view(views[i]);
      end
   end

   if (READ_REG) begin : g_flop
      logic [WORD_W-1:0] sel_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sel_q <= '0;
         else        sel_q <= sel_c;
      end
      assign rd_data = sel_q;
   end else begin : g_comb
      assign rd_data = sel_c;
   end

   // R13: reserved positions never carry data
   p_reserved_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & 32'hFFE0_FCE0) == '0);
endmodule

// File: rtl/rh_port_ctl.sv
module rh_port_ctl
   import rhp_pkg::*;
#(
   parameter int NPORTS   = 4,
   parameter bit READ_REG = 1'b0,
   parameter int PW       = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PW-1:0]     wr_port,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [PW-1:0]     rd_port,
   output logic [WORD_W-1:0] rd_data,
   input  logic [NPORTS-1:0] dev_connect,
   input  logic [NPORTS-1:0] dev_low_speed,
   input  logic [NPORTS-1:0] over_current,
   input  logic [NPORTS-1:0] reset_done,
   output logic [NPORTS-1:0] reset_active,
   output logic [NPORTS-1:0] resume_pulse
);
   if (NPORTS < 1 || NPORTS > 15) begin : g_bad_nports
      $error("rh_port_ctl: NPORTS must lie in 1..15");
   end
   if (PW < $clog2(NPORTS)) begin : g_bad_pw
      $error("rh_port_ctl: PW too narrow for NPORTS");
   end

   port_cmd_t  cmd   [NPORTS];
   port_view_t views [NPORTS];

   rhp_wr_decode #(.NPORTS(NPORTS), .PW(PW)) u_dec (
      .wr_en   (wr_en),
      .wr_port (wr_port),
      .wr_data (wr_data),
      .cmd     (cmd)
   );

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      rhp_port u_port (
         .clk           (clk),
         .rst_n         (rst_n),
         .cmd           (cmd[i]),
         .dev_connect   (dev_connect[i]),
         .dev_low_speed (dev_low_speed[i]),
         .over_current  (over_current[i]),
         .reset_done    (reset_done[i]),
         .view          (views[i]),
         .reset_active  (reset_active[i]),
         .resume_pulse  (resume_pulse[i])
      );
   end

   rhp_rd_mux #(.NPORTS(NPORTS), .PW(PW), .READ_REG(READ_REG)) u_mux (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_port (rd_port),
      .views   (views),
      .rd_data (rd_data)
   );
endmodule

// File: tb/rh_port_ctl_tb.sv
`timescale 1ns/100ps
module rh_port_ctl_tb;
   localparam int N  = 4;
   localparam int PW = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en;
   logic [PW-1:0] wr_port;
   logic [31:0]   wr_data;
   logic [PW-1:0] rd_port;
   logic [31:0]   rd_data;
   logic [N-1:0]  dev_connect, dev_low_speed, over_current, reset_done;
   logic [N-1:0]  reset_active, resume_pulse;

   int n_checks = 0;
   int n_err    = 0;

   bit [N-1:0] m_conn, m_en, m_susp, m_rst, m_pwr, m_res;
   bit [4:0]   m_chg [N];

   always #4 clk = ~clk;

   rh_port_ctl #(.NPORTS(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
      .wr_data(wr_data), .rd_port(rd_port), .rd_data(rd_data),
      .dev_connect(dev_connect), .dev_low_speed(dev_low_speed),
      .over_current(over_current), .reset_done(reset_done),
      .reset_active(reset_active), .resume_pulse(resume_pulse)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input int p);
      logic [31:0] w = '0;
      if (m_pwr[p]) begin
         w[0] = m_conn[p];
         w[1] = m_en[p];
         w[2] = m_susp[p];
         w[3] = over_current[p];
         w[4] = m_rst[p];
         w[8] = 1'b1;
         w[9] = m_conn[p] & dev_low_speed[p];
      end
      w[20:16] = m_chg[p];
      return w;
   endfunction

   task automatic rd_bit(input string tag, input int p, input int b, input bit exp);
      rd_port = PW'(p);
      #0.5;
      chk(tag, {31'b0, rd_data[b]}, {31'b0, exp});
   endtask

   task automatic tick();
      bit [N-1:0] nc, ne, ns, nr, np, nres;
      bit [4:0]   nch [N];
      for (int p = 0; p < N; p++) begin
         bit [31:0] w;
         bit c;
         w = (wr_en && wr_port == PW'(p)) ? wr_data : 32'h0;
         c = dev_connect[p];
         nc[p] = m_conn[p]; ne[p] = m_en[p]; ns[p] = m_susp[p];
         nr[p] = m_rst[p];  np[p] = m_pwr[p]; nres[p] = 1'b0;
         nch[p] = m_chg[p] & ~w[20:16];
         if (m_pwr[p]) begin
            if (w[1]) begin if (m_conn[p]) ne[p] = 1; else nch[p][0] = 1; end
            if (w[2] && m_en[p]) ns[p] = 1;
            if (w[0]) begin ne[p] = 0; ns[p] = 0; end
            if (w[3] && m_susp[p]) begin ns[p] = 0; nch[p][2] = 1; nres[p] = 1; end
            if (w[4]) begin if (m_conn[p]) nr[p] = 1; else nch[p][0] = 1; end
            if (reset_done[p] && m_rst[p]) begin nr[p] = 0; ne[p] = 1; nch[p][4] = 1; end
            nc[p] = c;
            if (c != m_conn[p]) nch[p][0] = 1;
            if (m_conn[p] && !c) begin
               if (m_en[p]) nch[p][1] = 1;
               ne[p] = 0; ns[p] = 0; nr[p] = 0;
            end
            if (over_current[p]) begin
               np[p] = 0; nch[p][3] = 1;
               if (m_en[p]) nch[p][1] = 1;
               nc[p] = 0; ne[p] = 0; ns[p] = 0; nr[p] = 0;
            end
            if (w[9]) begin np[p] = 0; nc[p] = 0; ne[p] = 0; ns[p] = 0; nr[p] = 0; end
         end else if (w[8] && !over_current[p]) begin
            np[p] = 1;
         end
      end
      @(posedge clk);
      m_conn = nc; m_en = ne; m_susp = ns; m_rst = nr; m_pwr = np; m_res = nres;
      for (int p = 0; p < N; p++) m_chg[p] = nch[p];
      #0.5;
      for (int p = 0; p < N; p++) begin
         rd_port = PW'(p);
         #0.5;
         chk("R12 per-cycle readback of every port", rd_data, exp_word(p));
      end
      chk("R8 reset_active vector", {28'b0, reset_active}, {28'b0, m_rst});
      chk("R7 resume_pulse vector", {28'b0, resume_pulse}, {28'b0, m_res});
      @(negedge clk);
   endtask

   task automatic wr(input int p, input logic [31:0] d);
      wr_en = 1'b1; wr_port = PW'(p); wr_data = d;
      tick();
      wr_en = 1'b0; wr_data = '0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired before the bench completed");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd2024));
      rst_n = 1'b0; wr_en = 1'b0; wr_port = '0; wr_data = '0; rd_port = '0;
      dev_connect = '0; dev_low_speed = '0; over_current = '0; reset_done = '0;
      m_conn = '0; m_en = '0; m_susp = '0; m_rst = '0; m_pwr = '0; m_res = '0;
      for (int p = 0; p < N; p++) m_chg[p] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int p = 0; p < N; p++) begin
         rd_port = PW'(p);
         #0.5;
         chk("R1 word during reset", rd_data, 32'h0);
      end
      chk("R1 outputs during reset", {28'b0, reset_active | resume_pulse}, 32'h0);
      rst_n = 1'b1;
      tick();

      // R3: commands on an unpowered port
      dev_connect[0] = 1'b1;
      wr(0, 32'h0000_0016);
      rd_bit("R3 enable ignored while off", 0, 1, 1'b0);
      rd_bit("R3 suspend ignored while off", 0, 2, 1'b0);
      rd_bit("R3 reset ignored while off", 0, 4, 1'b0);
      rd_bit("R3 connect hidden while off", 0, 0, 1'b0);
      // R2: power on, then an all-zero write
      wr(0, 32'h0000_0100);
      rd_bit("R2 power on", 0, 8, 1'b1);
      wr(0, 32'h0);
      rd_bit("R2 zero write keeps power", 0, 8, 1'b1);
      // R4: connect sampled, change flag
      rd_bit("R4 connect status", 0, 0, 1'b1);
      rd_bit("R4 connect change", 0, 16, 1'b1);
      // R11: acknowledge clears
      wr(0, 32'h0001_0000);
      rd_bit("R11 ack clears connect change", 0, 16, 1'b0);
      // R5: enable with and without a device
      wr(0, 32'h0000_0002);
      rd_bit("R5 enable connected port", 0, 1, 1'b1);
      wr(2, 32'h0000_0100);
      wr(2, 32'h0000_0002);
      rd_bit("R5 enable refused without device", 2, 1, 1'b0);
      rd_bit("R5 refused enable flags connect change", 2, 16, 1'b1);
      // R10: low speed
      dev_low_speed[0] = 1'b1;
      rd_bit("R10 low speed visible", 0, 9, 1'b1);
      dev_low_speed[0] = 1'b0;
      // R7: suspend and resume
      wr(0, 32'h0000_0004);
      rd_bit("R7 suspend set", 0, 2, 1'b1);
      wr(0, 32'h0000_0008);
      chk("R7 resume pulse raised", {31'b0, resume_pulse[0]}, 32'h1);
      rd_bit("R7 suspend cleared", 0, 2, 1'b0);
      rd_bit("R7 suspend change", 0, 18, 1'b1);
      tick();
      chk("R7 resume pulse single cycle", {31'b0, resume_pulse[0]}, 32'h0);
      // R8: port reset
      wr(0, 32'h0000_0010);
      rd_bit("R8 reset in progress", 0, 4, 1'b1);
      chk("R8 reset_active high", {31'b0, reset_active[0]}, 32'h1);
      reset_done[0] = 1'b1;
      tick();
      reset_done[0] = 1'b0;
      rd_bit("R8 reset ended", 0, 4, 1'b0);
      rd_bit("R8 reset enables port", 0, 1, 1'b1);
      rd_bit("R8 reset change", 0, 20, 1'b1);
      // R12: untouched ports
      rd_port = 2'd1; #0.5; chk("R12 port 1 untouched", rd_data, 32'h0);
      rd_port = 2'd3; #0.5; chk("R12 port 3 untouched", rd_data, 32'h0);
      // R6: disable command and disconnect
      wr(0, 32'h0000_0001);
      rd_bit("R6 clear enable", 0, 1, 1'b0);
      wr(0, 32'h0000_0002);
      dev_connect[0] = 1'b0;
      tick();
      rd_bit("R6 disconnect drops enable", 0, 1, 1'b0);
      rd_bit("R6 disconnect enable change", 0, 17, 1'b1);
      // R9: over-current
      dev_connect[0] = 1'b1;
      tick();
      wr(0, 32'h0000_0002);
      over_current[0] = 1'b1;
      rd_bit("R9 over-current reads", 0, 3, 1'b1);
      tick();
      rd_bit("R9 power removed", 0, 8, 1'b0);
      rd_bit("R9 over-current change", 0, 19, 1'b1);
      wr(0, 32'h0000_0100);
      rd_bit("R9 power refused during over-current", 0, 8, 1'b0);
      over_current[0] = 1'b0;
      // R11: event and acknowledge in one cycle
      dev_connect[2] = 1'b1;
      wr(2, 32'h0001_0000);
      rd_bit("R11 event beats acknowledge", 2, 16, 1'b1);
      // R2 / R3: power off hides status
      dev_low_speed[2] = 1'b1;
      wr(2, 32'h0000_0200);
      rd_bit("R2 power removed by bit 9", 2, 8, 1'b0);
      rd_bit("R3 low speed hidden while off", 2, 9, 1'b0);
      dev_low_speed[2] = 1'b0;

      // constrained random phase
      for (int cyc = 0; cyc < 3000; cyc++) begin
         wr_en   = ($urandom % 2) == 0;
         wr_port = PW'($urandom % N);
         if (($urandom % 8) == 0) wr_data = $urandom;
         else wr_data = 32'h1 << ($urandom % 21);
         for (int p = 0; p < N; p++) begin
            if (($urandom % 24) == 0) dev_connect[p] = ~dev_connect[p];
            dev_low_speed[p] = $urandom % 2;
            over_current[p]  = ($urandom % 80) == 0;
            reset_done[p]    = ($urandom % 6) == 0;
         end
         tick();
      end
      wr_en = 1'b0; over_current = '0; reset_done = '0;
      tick();
      for (int p = 0; p < N; p++) begin
         rd_port = PW'(p);
         #0.5;
         chk("R13 reserved bits zero", rd_data & 32'hFFE0_FCE0, 32'h0);
      end
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule